// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Hi/Lo Result Pair

This block performs 32-bit integer multiplication and division over several clock cycles. It holds its results in a dedicated pair of result registers, Hi and Lo, and not in the general register file. A single-cycle `start` pulse launches an operation and supplies two operands and a two-bit operation code. The unit then runs a fixed number of shift-add steps for a multiply, or shift-subtract steps for a divide. At the end it writes Hi and Lo and raises `done` for one cycle.

A multiply leaves a 64-bit product split across the pair, with the upper half in Hi. A divide leaves the quotient in Lo and the remainder in Hi. Signed operations run on operand magnitudes, and the signs are fixed up when the result is written back. Two read ports show Hi and Lo all the time, so move-from-Hi and move-from-Lo instructions can copy them into a general register whenever they like. Reading does not disturb either register. The surrounding pipeline holds off dependent instructions by watching `busy`.

Top module: `muldiv_hilo`

## Requirements
- R1: With op code 2'b00 (signed multiply), the unit writes the full 64-bit two's-complement product of the operands: bits 63:32 go to Hi and bits 31:0 go to Lo.
- R2: With op code 2'b01 (unsigned multiply), the unit writes the 64-bit natural-number product, split across Hi and Lo in the same way as R1.
- R3: With op code 2'b10 (signed divide), the quotient is truncated toward zero and goes to Lo. The remainder goes to Hi and carries the sign of the dividend.
- R4: With op code 2'b11 (unsigned divide), the unsigned quotient goes to Lo and the unsigned remainder goes to Hi.
- R5: The Hi and Lo read ports always show the stored register values, and reading them never changes those values.
- R6: After a start is accepted, `busy` stays high for exactly 32 cycles. `done` is high for exactly one cycle, which is the first cycle after `busy` falls.
- R7: A divide with a zero divisor still finishes on the normal schedule of R6, and it leaves Hi and Lo unchanged.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running operation keeps its operands, its op code and its timing.
- R9: Hi and Lo change only in the cycle in which `done` is high.
- R10: After reset, `busy` and `done` are low and Hi and Lo read zero.
- R11: A signed divide of 0x80000000 by 0xFFFFFFFF wraps: Lo reads 0x80000000 and Hi reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request; accepted only when `busy` is low |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the results are written |
| hi_q | output | 32 | Read port for the Hi register |
| lo_q | output | 32 | Read port for the Lo register |

## Verification
The bound checker watches the timing rules on every cycle:
- the 32-cycle busy window and the single-cycle `done` pulse;
- starts ignored while busy, through its own port-level cycle count;
- Hi and Lo held between completions and held across a divide by zero;
- unsigned products, against a reference product.

Only the bench scenarios can show signed product and quotient values, the truncation and remainder-sign rules, the wrap case, and that a start injected mid-run does not corrupt the result. The bench runs a mix of random operands and directed corners (zero, all-ones, mixed signs, small dividends) against its own model.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } mdu_op_e;

  function automatic logic op_is_div(input logic [1:0] o);
    return o[1];
  endfunction

  function automatic logic op_is_signed(input logic [1:0] o);
    return !o[0];
  endfunction
endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep #(
  parameter int unsigned W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         flip_main,
  output logic         flip_rem,
  output logic         is_div,
  output logic         b_zero
);
  import mdu_pkg::*;

  logic sgn, a_neg, b_neg;

  always_comb begin
    sgn       = op_is_signed(op);
    is_div    = op_is_div(op);
    a_neg     = sgn && a[W-1];
    b_neg     = sgn && b[W-1];
    mag_a     = a_neg ? (~a + W'(1)) : a;
    mag_b     = b_neg ? (~b + W'(1)) : b;
    flip_main = a_neg ^ b_neg;
    flip_rem  = a_neg && is_div;
    b_zero    = (b == '0);
  end
endmodule

// File: rtl/mdu_iter_core.sv
module mdu_iter_core #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           load_div,
  input  logic [W-1:0]   mag_a,
  input  logic [W-1:0]   mag_b,
  output logic [2*W-1:0] work_nxt
);
  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] work_q;
  logic [W-1:0]  opnd_q;
  logic          div_q;

  logic [W:0]    mul_sum;
  logic [DW-1:0] mul_nxt;
  logic [W:0]    shrem;
  logic [W+1:0]  diff;
  logic          fits;
  logic [DW-1:0] div_nxt;

  always_comb begin
    mul_sum = {1'b0, work_q[DW-1:W]} + (work_q[0] ? {1'b0, opnd_q} : '0);
    mul_nxt = {mul_sum, work_q[W-1:1]};
  end

  always_comb begin
    shrem   = work_q[DW-1:W-1];
    diff    = {1'b0, shrem} - {2'b00, opnd_q};
    fits    = !diff[W+1];
    div_nxt = {(fits ? diff[W-1:0] : shrem[W-1:0]), work_q[W-2:0], fits};
  end

  assign work_nxt = div_q ? div_nxt : mul_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      opnd_q <= '0;
      div_q  <= 1'b0;
    end else if (load) begin
      div_q  <= load_div;
      if (load_div) begin
        work_q <= {{W{1'b0}}, mag_a};
        opnd_q <= mag_b;
      end else begin
        work_q <= {{W{1'b0}}, mag_b};
        opnd_q <= mag_a;
      end
    end else if (step) begin
      work_q <= work_nxt;
    end
  end
endmodule

// File: rtl/mdu_seq_ctrl.sv
module mdu_seq_ctrl #(
  parameter int unsigned ITERS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic step,
  output logic last_step,
  output logic done
);
  localparam int unsigned CW = (ITERS > 1) ? $clog2(ITERS) : 1;

  logic [CW-1:0] cnt_q;

  assign accept    = start && !busy;
  assign step      = busy;
  assign last_step = busy && (cnt_q == CW'(ITERS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_step;
      if (accept) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + CW'(1);
        if (last_step) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int unsigned W     = 32,
  parameter int unsigned ITERS = W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  localparam int unsigned DW = 2 * W;

  logic [W-1:0]  mag_a, mag_b;
  logic          flip_main, flip_rem, in_div, in_bzero;
  logic          accept, step, last_step;
  logic [DW-1:0] work_nxt;

  logic          flip_main_q, flip_rem_q, div_q, bzero_q;
  logic          wr_en;
  logic [DW-1:0] prod_fix;
  logic [W-1:0]  quo_fix, rem_fix;
  logic [W-1:0]  hi_nxt, lo_nxt;

  mdu_operand_prep #(.W(W)) u_prep (
    .op        (op),
    .a         (src_a),
    .b         (src_b),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .flip_main (flip_main),
    .flip_rem  (flip_rem),
    .is_div    (in_div),
    .b_zero    (in_bzero)
  );

  mdu_seq_ctrl #(.ITERS(ITERS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .accept    (accept),
    .step      (step),
    .last_step (last_step),
    .done      (done)
  );

  mdu_iter_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (step),
    .load_div (in_div),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .work_nxt (work_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_main_q <= 1'b0;
      flip_rem_q  <= 1'b0;
      div_q       <= 1'b0;
      bzero_q     <= 1'b0;
    end else if (accept) begin
      flip_main_q <= flip_main;
      flip_rem_q  <= flip_rem;
      div_q       <= in_div;
      bzero_q     <= in_bzero;
    end
  end

  // sign correction applied to the final step's value
  always_comb begin
    prod_fix = flip_main_q ? (~work_nxt + DW'(1)) : work_nxt;
    quo_fix  = flip_main_q ? (~work_nxt[W-1:0] + W'(1)) : work_nxt[W-1:0];
    rem_fix  = flip_rem_q ? (~work_nxt[DW-1:W] + W'(1)) : work_nxt[DW-1:W];
    if (div_q) begin
      hi_nxt = rem_fix;
      lo_nxt = quo_fix;
    end else begin
      hi_nxt = prod_fix[DW-1:W];
      lo_nxt = prod_fix[W-1:0];
    end
  end

  assign wr_en = last_step && !(div_q && bzero_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int unsigned W     = 32,
  parameter int unsigned ITERS = W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int unsigned KW = $clog2(ITERS + 1) + 1;

  logic [KW-1:0] win_cnt;
  logic [1:0]    cap_op;
  logic [W-1:0]  cap_a, cap_b;
  logic          cap_dz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      cap_op  <= '0;
      cap_a   <= '0;
      cap_b   <= '0;
      cap_dz  <= 1'b0;
    end else if (start && !busy) begin
      win_cnt <= '0;
      cap_op  <= op;
      cap_a   <= src_a;
      cap_b   <= src_b;
      cap_dz  <= op[1] && (src_b == '0);
    end else if (busy) begin
      win_cnt <= win_cnt + KW'(1);
    end
  end

  a_r6_done_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (win_cnt == KW'(ITERS)));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (win_cnt < KW'(ITERS)));
  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi_q) && $stable(lo_q)));
  a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_dz) |-> ($stable(hi_q) && $stable(lo_q)));
  a_r2_unsigned_product: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == 2'b01) |-> ({hi_q, lo_q} == ({{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b})));
endmodule

bind muldiv_hilo mdu_checker #(.W(W), .ITERS(ITERS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .op    (op),
  .src_a (src_a),
  .src_b (src_b),
  .busy  (busy),
  .done  (done),
  .hi_q  (hi_q),
  .lo_q  (lo_q)
);

// File: tb/tb_muldiv_hilo.sv
`timescale 1ns/1ps
module tb_muldiv_hilo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] src_a = '0, src_b = '0;
  logic        busy, done;
  logic [31:0] hi_q, lo_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [31:0] hi_m = '0, lo_m = '0;

  always #4 clk = ~clk;

  muldiv_hilo dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
    .hi_q(hi_q), .lo_q(lo_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [63:0] prev);
    longint sa, sb, q, r;
    logic [63:0] p, qq, rr;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      2'b00: begin p = 64'(sa * sb); return p; end
      2'b01: return {32'b0, a} * {32'b0, b};
      2'b10: begin
        if (b == 0) return prev;
        q = sa / sb; r = sa % sb;
        qq = 64'(q); rr = 64'(r);
        return {rr[31:0], qq[31:0]};
      end
      default: begin
        if (b == 0) return prev;
        return {a % b, a / b};
      end
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input int inj, input string tag);
    logic [63:0] exp;
    bit tim_ok = 1;
    exp = model(o, a, b, {hi_m, lo_m});
    @(negedge clk);
    start = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0; src_a = $urandom; src_b = $urandom;
    for (int k = 0; k < 32; k++) begin
      if (!(busy && !done)) tim_ok = 0;
      start = (k == inj);
      if (k == inj) begin
        op = 2'($urandom); src_a = $urandom; src_b = $urandom;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (!(done && !busy)) tim_ok = 0;
    chk({hi_q, lo_q} == exp, tag, {hi_q, lo_q}, exp);
    hi_m = exp[63:32]; lo_m = exp[31:0];
    @(negedge clk);
    if (done) tim_ok = 0;
    chk(tim_ok, (inj >= 0) ? "R8 start while busy ignored (timing)" : "R6 busy window and done pulse",
        64'(tim_ok), 64'(1));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done, "R10 reset busy/done", {62'b0, busy, done}, 64'b0);
    chk(hi_q == 0 && lo_q == 0, "R10 reset hi/lo", {hi_q, lo_q}, 64'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_op(2'b00, 32'hFFFF_FFFF, 32'h0000_0003, -1, "R1 signed mul neg*pos");
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, -1, "R1 signed mul min*min");
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, -1, "R2 unsigned mul max*max");
    run_op(2'b01, 32'h0, 32'h1234_5678, -1, "R2 unsigned mul by zero");
    run_op(2'b10, 32'hFFFF_FFF9, 32'h0000_0002, -1, "R3 signed div -7/2");
    run_op(2'b10, 32'h0000_0007, 32'hFFFF_FFFE, -1, "R3 signed div 7/-2");
    run_op(2'b11, 32'hFFFF_FFF9, 32'h0000_0002, -1, "R4 unsigned div");
    run_op(2'b11, 32'h0000_0003, 32'h0000_0009, -1, "R4 unsigned div small dividend");
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, -1, "R11 signed div wrap");
    run_op(2'b01, 32'hDEAD_BEEF, 32'h0000_1001, -1, "R2 unsigned mul setup");
    run_op(2'b10, 32'h1234_5678, 32'h0, -1, "R7 signed div by zero keeps hi/lo");
    run_op(2'b11, 32'hFFFF_0000, 32'h0, -1, "R7 unsigned div by zero keeps hi/lo");
    run_op(2'b00, 32'h0000_1234, 32'hFFFF_0010, 5, "R8 start mid-run ignored (result)");
    run_op(2'b11, 32'hCAFE_F00D, 32'h0000_0777, 31, "R8 start on last busy cycle ignored");

    // R5 read ports hold values across idle cycles
    begin
      logic [63:0] seen;
      seen = {hi_q, lo_q};
      repeat (7) @(negedge clk);
      chk({hi_q, lo_q} == seen && seen == {hi_m, lo_m}, "R5 read ports stable", {hi_q, lo_q}, seen);
    end

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [1:0]  o;
      logic [31:0] a, b;
      o = 2'($urandom);
      a = $urandom;
      b = ($urandom % 4 == 0) ? ($urandom % 16) : $urandom;
      case (o)
        2'b00: run_op(o, a, b, -1, "R1 random signed mul");
        2'b01: run_op(o, a, b, -1, "R2 random unsigned mul");
        2'b10: run_op(o, a, b, (i % 5 == 0) ? i % 32 : -1, "R3 random signed div");
        default: run_op(o, a, b, -1, "R4 random unsigned div");
      endcase
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule